// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block generates several pulse-width-modulated outputs from one common time base. A prescaled up-counter runs from zero to a shared period value and then wraps. Every channel compares that count against its own threshold and drives its own output. Each channel has its own output mode and polarity, so duty cycle and polarity are set per channel while the period is common to all.

Software controls the block through a simple 32-bit register port with a write strobe and a combinational read path. While the counter is running, writes to the period and to channel thresholds are held in a shadow register and become active only at the next period start. Reads return the value that is currently active, so software can poll until a held write has landed. While the counter is stopped, these writes apply at once. Changes to channel mode and polarity bypass the shadow and reach the output in the next cycle. A per-channel match flag records that the count has passed the threshold, and software clears it by writing 1.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset, the register at offset 0x04 reads NUM_CH in bits [7:0]. The control (0x10), count (0x14), period (0x18) and all channel registers read 0, and every output is low.
- R2: With control bits [4:3] = 01, the count advances once every 2^ps clocks, where ps is control bits [2:0]. After a restart from count 0, the count reaches 1 exactly 2^ps cycles after the control write.
- R3: With control bits [4:3] at any value other than 01, the count holds its value. Control bit 5 is stored and read back, and has no effect on counting.
- R4: The count runs 0, 1, ..., P and then returns to 0, where P is the active period read at 0x18. A count at or above P always wraps at the next step. Any write to offset 0x14 sets the count to 0.
- R5: While stopped, a write to the period (0x18) or to channel n's threshold (0x24+8n) is read back at once as the active value.
- R6: While running, such a write is held. Reads keep returning the old value, and the old period still runs to its end. The new value becomes active at the wrap.
- R7: Channel n control sits at 0x20+8n. Bits [5:4] = 10 select edge-aligned PWM. Bits [3:2] = 10 select high-true output: the output is 1 while count < threshold, so a threshold of 0 gives a constant 0.
- R8: Bits [3:2] = 01 select inverted output: the output is 1 while count >= threshold.
- R9: Bits [3:2] = 11 act as high-true output. Bits [3:2] = 00, or bits [5:4] other than 10, hold the output at 0.
- R10: A change to channel control bits [5:2] reaches the output in the next cycle, without waiting for a wrap.
- R11: Channel control bit 7 is set when the counter steps while the count equals the threshold. Writing 1 to bit 7 clears it. Writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R12: A threshold above the active period gives a constant 1 for high-true output, and the match flag never sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a held period or threshold write that is still pending while the old period has not yet ended. Showing it needs the write to land in a known mid-period cycle, then a check that the old value is still read back and that the old period ran to its full length. The stimulus polls the count through the read port until it reaches a chosen value, issues the writes, and then follows the count cycle by cycle across the wrap. Polarity changes are made in the same way at a known count, so that a change taking effect immediately can be told apart from one deferred to the wrap.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   // Register offsets (software decodes these)
   localparam int OFS_PARAM   = 'h04;
   localparam int OFS_CTRL    = 'h10;
   localparam int OFS_COUNT   = 'h14;
   localparam int OFS_PERIOD  = 'h18;
   localparam int CH_BASE     = 'h20;
   localparam int CH_STRIDE   = 8;
   localparam int CH_VAL_OFS  = 4;

   typedef enum logic [1:0] {
      RUN_OFF  = 2'b00,
      RUN_CLK  = 2'b01,
      RUN_RSV2 = 2'b10,
      RUN_RSV3 = 2'b11
   } run_mode_e;

   typedef struct packed {
      logic       mode_b;
      logic       mode_a;
      logic [1:0] lvl;
   } ch_cfg_t;
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] ps_sel,
   output logic            tick
);
   localparam int DIV_W = (2 ** PS_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < DIV_W; i++) begin
         mask[i] = (ps_sel > PS_W'(i));
      end
   end

   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)    div_q <= '0;
      else if (run)  div_q <= div_q + 1'b1;
      else           div_q <= '0;
   end

   // R2: with a divide ratio above one, two ticks never come back to back
   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ps_sel != '0) |=> (!tick || ps_sel == '0));
endmodule

// File: rtl/pwmt_count.sv
module pwmt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             wr_count,
   input  logic             wr_period,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] period_act,
   output logic             period_start
);
   logic [CNT_W-1:0] cnt_q, per_act_q, per_buf_q;

   assign period_start = tick && (cnt_q >= per_act_q);
   assign cnt          = cnt_q;
   assign period_act   = per_act_q;

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (wr_count)     cnt_q <= '0;
      else if (period_start) cnt_q <= '0;
      else if (tick)         cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_act_q <= '0;
         per_buf_q <= '0;
      end else begin
         if (period_start) per_act_q <= per_buf_q;
         if (wr_period) begin
            per_buf_q <= wdata;
            if (!run) per_act_q <= wdata;
         end
      end
   end

   // R4: a step at or above the period always returns the count to zero
   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_q >= per_act_q) |=> (cnt_q == '0));
   // R3: a stopped counter keeps its value unless software clears it
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_count) |=> $stable(cnt_q));
   // R6: while running, the active period changes only at a period start
   assert_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !period_start) |=> $stable(per_act_q));
endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan
   import pwmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             period_start,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wr_ctl,
   input  logic             wr_val,
   input  ch_cfg_t          cfg_in,
   input  logic             clr_flag,
   input  logic [CNT_W-1:0] val_in,
   output logic             pwm_o,
   output logic [31:0]      ctl_rd,
   output logic [CNT_W-1:0] val_rd
);
   ch_cfg_t          cfg_q;
   logic             flag_q;
   logic [CNT_W-1:0] val_act_q, val_buf_q;
   logic             match_step, edge_mode, below;

   assign match_step = tick && (cnt == val_act_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_ctl) cfg_q <= cfg_in;
         if (match_step)               flag_q <= 1'b1;
         else if (wr_ctl && clr_flag)  flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_act_q <= '0;
         val_buf_q <= '0;
      end else begin
         if (period_start) val_act_q <= val_buf_q;
         if (wr_val) begin
            val_buf_q <= val_in;
            if (!run) val_act_q <= val_in;
         end
      end
   end

   assign edge_mode = cfg_q.mode_b && !cfg_q.mode_a;
   assign below     = cnt < val_act_q;

   always_comb begin
      unique case (cfg_q.lvl)
         2'b00:   pwm_o = 1'b0;
         2'b01:   pwm_o = edge_mode && !below;
         default: pwm_o = edge_mode && below;
      endcase
   end

   assign ctl_rd = {24'b0, flag_q, 1'b0, cfg_q.mode_b, cfg_q.mode_a, cfg_q.lvl, 2'b00};
   assign val_rd = val_act_q;

   // R9: writing a disabled level field forces the output low next cycle
   assert_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && cfg_in.lvl == 2'b00) |=> !pwm_o);
   // R11: a counter step on the threshold raises the flag
   assert_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      match_step |=> flag_q);
endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
   import pwmt_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16,
   parameter int PS_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam logic [ADDR_W-1:0] A_PARAM  = ADDR_W'(OFS_PARAM);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFS_PERIOD);

   // Elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 255) begin : g_bad_nch
      $error("NUM_CH must be 1..255");
   end
   if (CH_BASE + CH_STRIDE * NUM_CH > (2 ** ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for NUM_CH channels");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must be 2..32");
   end
   if (PS_W < 1 || PS_W > 3) begin : g_bad_ps
      $error("PS_W must be 1..3");
   end

   logic [PS_W-1:0]  ps_q;
   run_mode_e        mode_q;
   logic             center_q;
   logic             run, tick, period_start;
   logic             wr_ctrl, wr_count, wr_period;
   logic [CNT_W-1:0] cnt, period_act;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
   assign wr_count  = bus_wr && (bus_addr == A_COUNT);
   assign wr_period = bus_wr && (bus_addr == A_PERIOD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_q     <= '0;
         mode_q   <= RUN_OFF;
         center_q <= 1'b0;
      end else if (wr_ctrl) begin
         ps_q     <= bus_wdata[PS_W-1:0];
         mode_q   <= run_mode_e'(bus_wdata[4:3]);
         center_q <= bus_wdata[5];
      end
   end

   assign run = (mode_q == RUN_CLK);

   pwmt_prescale #(.PS_W(PS_W)) u_ps (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .ps_sel (ps_q),
      .tick   (tick)
   );

   pwmt_count #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .tick         (tick),
      .wr_count     (wr_count),
      .wr_period    (wr_period),
      .wdata        (bus_wdata[CNT_W-1:0]),
      .cnt          (cnt),
      .period_act   (period_act),
      .period_start (period_start)
   );

   logic [31:0]      ch_ctl_rd [NUM_CH];
   logic [CNT_W-1:0] ch_val_rd [NUM_CH];
   ch_cfg_t          cfg_in;

   assign cfg_in = '{mode_b: bus_wdata[5], mode_a: bus_wdata[4], lvl: bus_wdata[3:2]};

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CH_BASE + CH_STRIDE * g);
      localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(CH_BASE + CH_STRIDE * g + CH_VAL_OFS);

      pwmt_chan #(.CNT_W(CNT_W)) u_ch (
         .clk          (clk),
         .rst_n        (rst_n),
         .run          (run),
         .tick         (tick),
         .period_start (period_start),
         .cnt          (cnt),
         .wr_ctl       (bus_wr && (bus_addr == A_CTL)),
         .wr_val       (bus_wr && (bus_addr == A_VAL)),
         .cfg_in       (cfg_in),
         .clr_flag     (bus_wdata[7]),
         .val_in       (bus_wdata[CNT_W-1:0]),
         .pwm_o        (pwm_out[g]),
         .ctl_rd       (ch_ctl_rd[g]),
         .val_rd       (ch_val_rd[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_PARAM)       bus_rdata[7:0] = 8'(NUM_CH);
      else if (bus_addr == A_CTRL)   bus_rdata[5:0] = {center_q, mode_q, 3'(ps_q)};
      else if (bus_addr == A_COUNT)  bus_rdata = 32'(cnt);
      else if (bus_addr == A_PERIOD) bus_rdata = 32'(period_act);
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i))
            bus_rdata = ch_ctl_rd[i];
         if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_VAL_OFS))
            bus_rdata = 32'(ch_val_rd[i]);
      end
   end

   // R1: while held in reset, no output is driven high after the first edge
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (pwm_out == '0));
endmodule

// File: tb/sim_pwm_shared_timer.sv
module sim_pwm_shared_timer;
   localparam int CLK_PERIOD = 20;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] pwm_out;

   int n_chk = 0;
   int n_fail = 0;

   logic       m_mb [NCH];
   logic       m_ma [NCH];
   logic [1:0] m_lvl [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_shared_timer #(.NUM_CH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_cfg(input int i, input logic mb, input logic ma, input logic [1:0] lvl);
      wr(8'(32 + 8*i), {24'b0, 2'b00, mb, ma, lvl, 2'b00});
      m_mb[i] = mb; m_ma[i] = ma; m_lvl[i] = lvl;
   endtask

   function automatic logic exp_pwm(input int i, input logic [31:0] c, input logic [31:0] v);
      logic em;
      logic below;
      em = m_mb[i] && !m_ma[i];
      below = c < v;
      case (m_lvl[i])
         2'b00:   return 1'b0;
         2'b01:   return em && !below;
         default: return em && below;
      endcase
   endfunction

   // R7 R8 R9 R12: outputs against count and active thresholds
   task automatic check_outs(input string tag);
      logic [31:0] c;
      logic [31:0] v;
      rd(8'h14, c);
      for (int i = 0; i < NCH; i++) begin
         rd(8'(36 + 8*i), v);
         chk($sformatf("%s ch%0d", tag, i), 32'(pwm_out[i]), 32'(exp_pwm(i, c, v)));
      end
   endtask

   // R4: count sequence against an arithmetic model
   task automatic sweep(input int cycles, input int per, input string tag);
      logic [31:0] c;
      int e;
      rd(8'h14, c);
      e = int'(c);
      for (int k = 0; k < cycles; k++) begin
         check_outs(tag);
         @(negedge clk);
         e = (e >= per) ? 0 : e + 1;
         rd(8'h14, c);
         chk({"R4 count ", tag}, c, 32'(e));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] c0;
      logic [31:0] prev;
      int n;
      for (int i = 0; i < NCH; i++) begin m_mb[i] = 0; m_ma[i] = 0; m_lvl[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h04, d); chk("R1 param", d, 32'(NCH));
      rd(8'h10, d); chk("R1 ctrl", d, 0);
      rd(8'h14, d); chk("R1 count", d, 0);
      rd(8'h18, d); chk("R1 period", d, 0);
      rd(8'h20, d); chk("R1 ch0 ctl", d, 0);
      rd(8'h3C, d); chk("R1 ch3 val", d, 0);
      chk("R1 outputs", 32'(pwm_out), 0);

      // R5 immediate writes while stopped
      wr(8'h18, 9);  rd(8'h18, d); chk("R5 period", d, 9);
      wr(8'h24, 3);  rd(8'h24, d); chk("R5 ch0 val", d, 3);
      wr(8'h2C, 5);  rd(8'h2C, d); chk("R5 ch1 val", d, 5);
      wr(8'h34, 4);  rd(8'h34, d); chk("R5 ch2 val", d, 4);
      wr(8'h3C, 10); rd(8'h3C, d); chk("R5 ch3 val", d, 10);

      set_cfg(0, 1, 0, 2'b10);  // R7 high-true
      set_cfg(1, 1, 0, 2'b01);  // R8 inverted
      set_cfg(2, 1, 0, 2'b00);  // R9 disabled
      set_cfg(3, 1, 0, 2'b11);  // R9 reserved as high-true, R12 above period
      check_outs("R7/R8/R9 stopped");

      // R3 stopped counter holds
      repeat (3) @(negedge clk);
      rd(8'h14, d); chk("R3 stopped count", d, 0);

      // run, ps 0: full sweep
      wr(8'h10, 32'h08);
      sweep(25, 9, "R7 run");

      // R11 / R12 flags
      wr(8'h10, 32'h00);
      rd(8'h20, d); chk("R11 ch0 flag set", 32'(d[7]), 1);
      rd(8'h38, d); chk("R12 ch3 flag never", 32'(d[7]), 0);
      wr(8'h20, 32'h28); rd(8'h20, d); chk("R11 write 0 keeps flag", 32'(d[7]), 1);
      wr(8'h20, 32'hA8); rd(8'h20, d); chk("R11 write 1 clears flag", 32'(d[7]), 0);

      // R3 reserved mode also holds
      wr(8'h10, 32'h10);
      rd(8'h14, c0);
      repeat (4) @(negedge clk);
      rd(8'h14, d); chk("R3 mode 10 holds", d, c0);

      // R2 prescaler sweep
      for (int ps = 0; ps < 8; ps++) begin
         wr(8'h10, 32'h00);
         wr(8'h14, 32'h0);
         wr(8'h10, 32'h08 | 32'(ps));
         n = 0;
         d = 0;
         while (d != 1 && n < 300) begin
            @(negedge clk);
            n++;
            rd(8'h14, d);
         end
         chk($sformatf("R2 ps=%0d step", ps), 32'(n), 32'(1 << ps));
      end

      // R3 center bit stored, no effect
      wr(8'h10, 32'h28);
      rd(8'h10, d); chk("R3 center bit readback", d, 32'h28);
      sweep(12, 9, "R3 center ignored");

      // R4 counter write clears
      wr(8'h14, 32'hFFFF);
      rd(8'h14, d); chk("R4 count write clears", d, 0);

      // R6 buffered writes while running
      d = 99;
      while (d != 2) begin @(negedge clk); rd(8'h14, d); end
      wr(8'h18, 5);
      rd(8'h18, d); chk("R6 period old value held", d, 9);
      wr(8'h24, 1);
      rd(8'h24, d); chk("R6 ch0 val old value held", d, 3);
      rd(8'h14, prev);
      n = 0;
      d = prev;
      while (!(d == 0 && prev != 0) && n < 40) begin
         prev = d;
         @(negedge clk);
         n++;
         rd(8'h14, d);
      end
      chk("R6 old period ran to end", prev, 9);
      rd(8'h18, d); chk("R6 period loaded at wrap", d, 5);
      rd(8'h24, d); chk("R6 ch0 val loaded at wrap", d, 1);
      sweep(14, 5, "R6 new period");

      // R10 immediate polarity / mode changes
      d = 99;
      while (d != 1) begin @(negedge clk); rd(8'h14, d); end
      set_cfg(1, 1, 0, 2'b10);
      rd(8'h14, d); chk("R10 no wrap in between", 32'(d == 0), 0);
      chk("R10 ch1 now high-true", 32'(pwm_out[1]), 32'(d < 5));
      check_outs("R10 polarity");
      set_cfg(0, 1, 0, 2'b00);
      check_outs("R10 disable");
      set_cfg(3, 0, 1, 2'b10);
      chk("R9 non-edge mode low", 32'(pwm_out[3]), 0);
      sweep(8, 5, "R9 modes");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule